// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

The block drives four pulse-width-modulated outputs from one system clock through a small word-wide register port. Each channel counts down from a period value and holds its output high while the count is at or below a comparator value. Channels run in pairs from a shared 8-bit prescaler. Each channel then has its own clock divider, whose code-to-ratio mapping does not follow code order.

A channel runs either continuously, reloading at the end of every period, or as a one-shot that covers a single period and then returns to idle. An invert bit complements the output. Each channel pulses a period-end flag whenever its count passes zero. The live count of each channel can be read back. New period and comparator values are held in shadow registers and only take effect at the next reload or start.

Top module: `pwm4_unit`

## Requirements
- R1: After reset every register reads 0, and `pwm_out` and `period_end` are all 0.
- R2: Writes take effect at the clock edge that samples `bus_we`. Reads are combinational from `bus_addr`.
  - Prescaler register at 0x00: channels 0/1 use bits [7:0], channels 2/3 use bits [15:8].
  - Divider-select register at 0x04: a 3-bit code per channel at bit 4·i.
  - Control register at 0x08: a field per channel at bit 0, 8, 12 or 16. In each field, bit 0 is enable, bit 2 is invert and bit 3 is auto-reload. Field bit 1 reads 0.
  - Channel i has its period at 0x0C+12·i, its comparator at 0x10+12·i and its live count at 0x14+12·i. These are 16 bits, and the upper bits read 0.
- R3: A prescaler value P produces one tick every P+1 clocks, free-running from reset. The tick is shared by both channels of the pair.
- R4: Divider codes map as 0→/2, 1→/4, 2→/8, 3→/16 and 4→/1. Codes 5 to 7 also give /1. A channel's divider restarts when the channel starts.
- R5: A period value N gives N+1 divided ticks per period. The count steps N, N−1 … 0. `period_end` is high for one clock after each step out of 0.
- R6: With comparator M < N, the uninverted output is high while the count is ≤ M, which is M+1 of every N+1 ticks.
- R7: With M ≥ N, the uninverted output is high for the whole period.
- R8: A channel enabled with period 0 does not run and its uninverted output stays low. An auto-reload channel whose shadow period is 0 at reload stops.
- R9: The invert bit complements the output in every state, so a stopped channel with invert set drives 1.
- R10: In one-shot mode the channel stops after one period and drives its idle level. Only a 0→1 transition of enable starts it again.
- R11: Period and comparator writes made while a channel runs take effect only at its next reload.
- R12: The channel loads its count one clock after enable rises. Clearing enable stops the channel at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pwm_out | output | 4 | Channel waveforms |
| period_end | output | 4 | One-clock flag per channel at end of period |

## Verification
The bench targets the following corner cases:
- **Comparator boundary.** M = N−1 against M ≥ N. A design with an exclusive comparator would lose a tick of high time in every period.
- **Divider mapping.** The /1 code and a reserved code, where a monotonic decoder would turn code 4 into /32.
- **Zero period.** A zero period arriving either at start or at a live reload. A design that loaded zero and ran would emit a period-end flag on every tick.
- **Period changes under way.** Period changes while running, which an unshadowed design would apply mid-period.
- **One-shot end and retrigger.** A design that reloads would keep toggling, and one that restarts on a level would fire again without an enable edge.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

   localparam int CS_W = 3;

   typedef struct packed {
      logic en;
      logic inv;
      logic auto_rl;
   } chan_ctl_t;

   // last value of the divide counter for a divider code
   function automatic logic [3:0] div_last(input logic [2:0] code);
      case (code)
         3'd0:    return 4'd1;
         3'd1:    return 4'd3;
         3'd2:    return 4'd7;
         3'd3:    return 4'd15;
         default: return 4'd0;
      endcase
   endfunction

   function automatic int pre_lsb(input int pair, input int pre_w);
      return pre_w * pair;
   endfunction

   function automatic int cs_lsb(input int ch);
      return 4 * ch;
   endfunction

   function automatic int ctl_lsb(input int ch);
      return (ch == 0) ? 0 : 4 + 4 * ch;
   endfunction

   function automatic int chan_base(input int ch);
      return 12 + 12 * ch;
   endfunction

endpackage

// File: rtl/pwm4_prescaler.sv
module pwm4_prescaler #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] div_val,
   output logic             tick
);
   logic [PRE_W-1:0] cnt;

   assign tick = (cnt >= div_val);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   assert_pre_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> (cnt == $past(cnt) + 1'b1));
   assert_pre_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt == '0));
endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel
   import pwm4_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  chan_ctl_t        ctl,
   input  logic [CS_W-1:0]  div_code,
   input  logic             pre_tick,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] live_cnt,
   output logic             wave,
   output logic             period_end
);
   logic             running, en_d, start, ch_tick;
   logic [CNT_W-1:0] cnt, m_act;
   logic [3:0]       divcnt;

   assign start    = ctl.en & ~en_d;
   assign ch_tick  = pre_tick & (divcnt == div_last(div_code));
   assign live_cnt = cnt;
   assign wave     = (running && (cnt <= m_act)) ^ ctl.inv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running    <= 1'b0;
         en_d       <= 1'b0;
         cnt        <= '0;
         m_act      <= '0;
         divcnt     <= '0;
         period_end <= 1'b0;
      end else begin
         en_d       <= ctl.en;
         period_end <= 1'b0;
         if (!ctl.en) begin
            running <= 1'b0;
         end else if (start) begin
            running <= (period != '0);
            cnt     <= period;
            m_act   <= cmp;
            divcnt  <= '0;
         end else if (running && pre_tick) begin
            if (ch_tick) begin
               divcnt <= '0;
               if (cnt == '0) begin
                  period_end <= 1'b1;
                  if (ctl.auto_rl && period != '0) begin
                     cnt   <= period;
                     m_act <= cmp;
                  end else begin
                     running <= 1'b0;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end else begin
               divcnt <= divcnt + 1'b1;
            end
         end
      end
   end

   assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (running && ctl.en && !start && ch_tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
   assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (running && ctl.en && !start && !pre_tick) |=> $stable(cnt));
   assert_pend_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      period_end |-> $past(running));
   assert_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.en |=> !running);
   assert_zero_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && period == '0) |=> !running);
endmodule

// File: rtl/pwm4_regs.sv
module pwm4_regs
   import pwm4_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int CNT_W   = 16,
   parameter int PRE_W   = 8,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   localparam int NUM_PAIR = NUM_CH / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [CNT_W-1:0]  live_cnt [NUM_CH],
   output logic [PRE_W-1:0]  pre_val  [NUM_PAIR],
   output logic [CS_W-1:0]   cs_code  [NUM_CH],
   output chan_ctl_t         ctl      [NUM_CH],
   output logic [CNT_W-1:0]  period   [NUM_CH],
   output logic [CNT_W-1:0]  cmp      [NUM_CH]
);
   localparam logic [ADDR_W-1:0] A_PRE = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_CS  = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(8);

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_PAIR; p++) pre_val[p] <= '0;
         for (int i = 0; i < NUM_CH; i++) begin
            cs_code[i] <= '0;
            ctl[i]     <= '0;
            period[i]  <= '0;
            cmp[i]     <= '0;
         end
      end else if (we) begin
         if (addr == A_PRE)
            for (int p = 0; p < NUM_PAIR; p++)
               pre_val[p] <= wdata[pre_lsb(p, PRE_W) +: PRE_W];
         if (addr == A_CS)
            for (int i = 0; i < NUM_CH; i++)
               cs_code[i] <= wdata[cs_lsb(i) +: CS_W];
         if (addr == A_CTL)
            for (int i = 0; i < NUM_CH; i++) begin
               ctl[i].en      <= wdata[ctl_lsb(i)];
               ctl[i].inv     <= wdata[ctl_lsb(i) + 2];
               ctl[i].auto_rl <= wdata[ctl_lsb(i) + 3];
            end
         for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(chan_base(i)))     period[i] <= wdata[CNT_W-1:0];
            if (addr == ADDR_W'(chan_base(i) + 4)) cmp[i]    <= wdata[CNT_W-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_PRE)
         for (int p = 0; p < NUM_PAIR; p++) rdata[pre_lsb(p, PRE_W) +: PRE_W] = pre_val[p];
      if (addr == A_CS)
         for (int i = 0; i < NUM_CH; i++) rdata[cs_lsb(i) +: CS_W] = cs_code[i];
      if (addr == A_CTL)
         for (int i = 0; i < NUM_CH; i++) begin
            rdata[ctl_lsb(i)]     = ctl[i].en;
            rdata[ctl_lsb(i) + 2] = ctl[i].inv;
            rdata[ctl_lsb(i) + 3] = ctl[i].auto_rl;
         end
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr == ADDR_W'(chan_base(i)))     rdata[CNT_W-1:0] = period[i];
         if (addr == ADDR_W'(chan_base(i) + 4)) rdata[CNT_W-1:0] = cmp[i];
         if (addr == ADDR_W'(chan_base(i) + 8)) rdata[CNT_W-1:0] = live_cnt[i];
      end
   end

   assert_period_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(chan_base(0))) |=> (period[0] == $past(wdata[CNT_W-1:0])));
   assert_cmp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(cmp[0]));
endmodule

// File: rtl/pwm4_unit.sv
module pwm4_unit
   import pwm4_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 16,
   parameter int PRE_W  = 8,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] pwm_out,
   output logic [NUM_CH-1:0] period_end
);
   localparam int NUM_PAIR = NUM_CH / 2;

   if (NUM_CH < 2 || NUM_CH > 4 || (NUM_CH % 2) != 0) begin : g_bad_ch
      $error("pwm4_unit: NUM_CH must be 2 or 4");
   end
   if (CNT_W > DATA_W || PRE_W * NUM_PAIR > DATA_W) begin : g_bad_w
      $error("pwm4_unit: field widths exceed the data word");
   end
   if (ADDR_W < 6) begin : g_bad_a
      $error("pwm4_unit: address too narrow for the register map");
   end

   logic [PRE_W-1:0] pre_val  [NUM_PAIR];
   logic             pre_tick [NUM_PAIR];
   logic [CS_W-1:0]  cs_code  [NUM_CH];
   chan_ctl_t        ctl      [NUM_CH];
   logic [CNT_W-1:0] period   [NUM_CH];
   logic [CNT_W-1:0] cmp      [NUM_CH];
   logic [CNT_W-1:0] live_cnt [NUM_CH];

   pwm4_regs #(
      .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .rdata(bus_rdata), .live_cnt(live_cnt), .pre_val(pre_val), .cs_code(cs_code),
      .ctl(ctl), .period(period), .cmp(cmp)
   );

   for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
      pwm4_prescaler #(.PRE_W(PRE_W)) u_pre (
         .clk(clk), .rst_n(rst_n), .div_val(pre_val[p]), .tick(pre_tick[p])
      );
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      pwm4_channel #(.CNT_W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .ctl(ctl[i]), .div_code(cs_code[i]),
         .pre_tick(pre_tick[i/2]), .period(period[i]), .cmp(cmp[i]),
         .live_cnt(live_cnt[i]), .wave(pwm_out[i]), .period_end(period_end[i])
      );
   end
endmodule

// File: tb/pwm4_unit_test.sv
`timescale 1ns/1ps
module pwm4_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  pwm_out, period_end;

   pwm4_unit uut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .period_end(period_end));

   always #4 clk = ~clk;

   int n_chk = 0, n_err = 0;
   bit finished = 0, cmp_on = 0;
   string cur_req = "R1";

   // shadow of written registers and behavioural model state
   int m_pre, m_cs, m_ctl;
   int m_per [4], m_cmp [4];
   int pcnt [2];
   int run [4], cnt [4], mact [4], dcnt [4], enp [4], pend [4];

   function automatic int fld(input int c);
      return (c == 0) ? 0 : 4 + 4 * c;
   endfunction
   function automatic int ratio(input int code);
      case (code)
         0: return 2;
         1: return 4;
         2: return 8;
         3: return 16;
         default: return 1;
      endcase
   endfunction
   function automatic int exp_wave(input int c);
      int raw;
      raw = (run[c] != 0 && cnt[c] <= mact[c]) ? 1 : 0;
      return raw ^ ((m_ctl >> (fld(c) + 2)) & 1);
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre = 0; m_cs = 0; m_ctl = 0;
         for (int c = 0; c < 4; c++) begin
            m_per[c] = 0; m_cmp[c] = 0; run[c] = 0; cnt[c] = 0;
            mact[c] = 0; dcnt[c] = 0; enp[c] = 0; pend[c] = 0;
         end
         pcnt[0] = 0; pcnt[1] = 0;
      end else begin
         int tk [2];
         for (int p = 0; p < 2; p++) tk[p] = (pcnt[p] >= ((m_pre >> (8*p)) & 255)) ? 1 : 0;
         for (int c = 0; c < 4; c++) begin
            int en, rl;
            en = (m_ctl >> fld(c)) & 1;
            rl = (m_ctl >> (fld(c) + 3)) & 1;
            pend[c] = 0;
            if (en == 0) run[c] = 0;
            else if (enp[c] == 0) begin
               run[c] = (m_per[c] != 0); cnt[c] = m_per[c]; mact[c] = m_cmp[c]; dcnt[c] = 0;
            end else if (run[c] != 0 && tk[c/2] != 0) begin
               if (dcnt[c] + 1 == ratio((m_cs >> (4*c)) & 7)) begin
                  dcnt[c] = 0;
                  if (cnt[c] == 0) begin
                     pend[c] = 1;
                     if (rl != 0 && m_per[c] != 0) begin cnt[c] = m_per[c]; mact[c] = m_cmp[c]; end
                     else run[c] = 0;
                  end else cnt[c]--;
               end else dcnt[c]++;
            end
            enp[c] = en;
         end
         for (int p = 0; p < 2; p++) pcnt[p] = (tk[p] != 0) ? 0 : pcnt[p] + 1;
         if (bus_we) begin
            case (bus_addr)
               8'h00: m_pre = bus_wdata & 32'hFFFF;
               8'h04: m_cs  = bus_wdata & 32'h7777;
               8'h08: m_ctl = bus_wdata & 32'hDDD0D;
               default: ;
            endcase
            for (int c = 0; c < 4; c++) begin
               if (bus_addr == 8'(12 + 12*c)) m_per[c] = bus_wdata & 32'hFFFF;
               if (bus_addr == 8'(16 + 12*c)) m_cmp[c] = bus_wdata & 32'hFFFF;
            end
         end
      end
   end

   // every-clock comparison of the waveforms and period-end flags
   always @(negedge clk) begin
      if (cmp_on) begin
         for (int c = 0; c < 4; c++) begin
            chk({31'd0, pwm_out[c]}, 32'(exp_wave(c)), cur_req);
            chk({31'd0, period_end[c]}, 32'(pend[c]), cur_req);
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(bus_rdata, exp, req);
   endtask

   task automatic rd_live(input int c, input string req);
      @(negedge clk);
      bus_addr = 8'(20 + 12*c);
      #1;
      chk(bus_rdata, 32'(cnt[c]), req);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      rd(8'h00, 0, "R1"); rd(8'h08, 0, "R1"); rd(8'h0C, 0, "R1"); rd(8'h38, 0, "R1");
      chk({28'd0, pwm_out}, 0, "R1");
      chk({28'd0, period_end}, 0, "R1");
      cmp_on = 1;

      // R3 R4 R5 R6 R7: pair prescalers 2 and 0; divider codes 4,0,3,6
      cur_req = "R2";
      wr(8'h00, 32'h0002);
      wr(8'h04, 32'h6304);
      wr(8'h0C, 4);  wr(8'h10, 1);   // ch0 N=4 M=1
      wr(8'h18, 3);  wr(8'h1C, 5);   // ch1 full high, inverted
      wr(8'h24, 2);  wr(8'h28, 0);   // ch2 one-shot
      wr(8'h30, 5);  wr(8'h34, 4);   // ch3 M = N-1
      rd(8'h00, 32'h0002, "R2"); rd(8'h04, 32'h6304, "R2");
      rd(8'h1C, 5, "R2"); rd(8'h30, 5, "R2");
      cur_req = "R6";
      wr(8'h08, 32'h91D09);
      rd(8'h08, 32'h91D09, "R2");
      wait_n(2);
      rd_live(0, "R5");
      cur_req = "R4";
      wait_n(150);
      rd_live(2, "R5"); rd_live(3, "R5");
      cur_req = "R10";
      wait_n(60);
      chk({31'd0, pwm_out[2]}, 0, "R10");

      // R11: shadowed period and comparator change while running
      cur_req = "R11";
      wr(8'h0C, 7); wr(8'h10, 3);
      wait_n(120);
      rd_live(0, "R11");

      // R8: zero period reaching an auto-reload channel
      cur_req = "R8";
      wr(8'h30, 0);
      wait_n(60);
      chk({31'd0, pwm_out[3]}, 0, "R8");

      // R10: one-shot restart only on an enable edge
      cur_req = "R10";
      wr(8'h08, 32'h90D09);
      wr(8'h08, 32'h91D09);
      wait_n(80);
      chk({31'd0, pwm_out[2]}, 0, "R10");

      // R9 R8: stopped inverted channel drives high
      cur_req = "R9";
      wr(8'h08, 32'h91009);
      wr(8'h18, 0);
      wr(8'h08, 32'h91D09);
      wait_n(20);
      chk({31'd0, pwm_out[1]}, 1, "R9");

      // R12: clearing all enables stops every channel
      cur_req = "R12";
      wr(8'h08, 32'h00000);
      wait_n(30);
      chk({28'd0, pwm_out}, 0, "R12");
      rd_live(0, "R12");

      cmp_on = 0;
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule